// File: doc/BRIEF.md
# Physical Register Rename Stage with Free List

This block is the single-wide rename stage of an out-of-order core whose register values all live in one physical register file. Each decoded instruction has its source architectural registers translated to physical register numbers through a speculative mapping table. No register values are read here. An instruction that writes a register is given a fresh physical register from a FIFO free list. The table is then pointed at that register, and the mapping it replaces is kept in a program-ordered history of in-flight instructions.

Commit works only on mappings. Retiring the oldest history entry hands its replaced physical register back to the free list, because no older reader can still need it. Commit moves no data.

A trap discards all uncommitted work. The stage walks the history from the youngest entry to the oldest, one entry per cycle. At each step it writes the saved previous mapping back into the table and returns the speculatively allocated register to the free list. When the walk ends it raises a one-cycle done pulse. A ready bit per physical register goes with every renamed source, so the scheduler knows whether the value has been produced.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds the physical registers NUM_ARCH to NUM_PHYS-1 in ascending order, with NUM_ARCH first at its head. Every ready bit is set, the history is empty and `dec_ready` is high.
- R2: While a decode is accepted, `ren_psrc_a` and `ren_psrc_b` show the current table mapping of the two sources. The mapping is read before the same instruction's destination update, so a source equal to its own destination gets the older mapping.
- R3: An accepted decode with `dec_has_dst` set takes the free list head, shown on `ren_pdst`. `ren_pold` shows the destination's previous mapping. From the next cycle the table maps the destination to the new register.
- R4: `ren_psrc_a_rdy` and `ren_psrc_b_rdy` give the ready bit of the mapped register as it stands at the start of the cycle. Allocating a register clears its bit, and `wb_valid` sets the bit of `wb_preg`. When both touch one register in the same cycle, the allocation wins.
- R5: `cmt_valid` retires the oldest history entry. If that entry had a destination, its previous mapping is appended to the tail of the free list. A commit is ignored when the history is empty.
- R6: `dec_ready` is low when the free list is empty, when the history holds DEPTH entries, in the trap cycle, or during recovery. A decode offered while `dec_ready` is low changes neither the table nor the free list.
- R7: After `trap`, the stage enters recovery. Each cycle it undoes the youngest entry: the saved previous mapping is written back and the new register is appended to the free list. Entries without a destination are dropped. Commits are ignored from the trap cycle until recovery ends.
- R8: `rec_done` is high for exactly one cycle, in the first recovery cycle that finds the history empty. Decode is accepted again on the next cycle. A trap with an empty history therefore gives `rec_done` on the cycle after the trap.
- R9: The free register count plus the number of in-flight entries with a destination always equals NUM_PHYS-NUM_ARCH.
- R10: A `trap` raised while recovery is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction offered |
| dec_ready | output | 1 | Rename can accept this cycle |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_src_a | input | 3 | First source architectural register |
| dec_src_b | input | 3 | Second source architectural register |
| dec_dst | input | 3 | Destination architectural register |
| ren_psrc_a | output | 4 | Physical register of first source |
| ren_psrc_a_rdy | output | 1 | First source value present |
| ren_psrc_b | output | 4 | Physical register of second source |
| ren_psrc_b_rdy | output | 1 | Second source value present |
| ren_pdst | output | 4 | Newly allocated destination register |
| ren_pold | output | 4 | Destination's previous mapping |
| wb_valid | input | 1 | Writeback of a physical register |
| wb_preg | input | 4 | Register being written back |
| cmt_valid | input | 1 | Retire the oldest in-flight instruction |
| trap | input | 1 | Discard uncommitted instructions |
| rec_done | output | 1 | Recovery walk finished (one cycle) |

## Verification
Some properties are checked on every cycle:
- Register conservation between the free list and the in-flight history.
- No pop from an empty free list or history, and no push into a full one.
- Decode stays blocked during recovery, and the done pulse lasts one cycle.
- The table picks up each allocation on the following cycle, and the ready bit of each newly allocated register is cleared.
- A committing entry's previous register is never still mapped.

Other behaviour is shown only by the bench's cycle-by-cycle model, across directed and random scenarios:
- The FIFO order in which freed registers are reused.
- The exact mappings restored after a youngest-first walk.
- The length of the walk and the position of the done pulse.
- That a commit or second trap during recovery, or a stalled decode, leaves no trace.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_UNDO = 1'b1
  } rn_mode_e;

  // Ring index arithmetic shared by the free list and the history.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1 == size) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned ring_prev(int unsigned idx, int unsigned size);
    return (idx == 0) ? size - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NUM_PHYS = 16,
  parameter int NUM_ARCH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pop,
  input  logic                              push,
  input  logic [$clog2(NUM_PHYS)-1:0]       push_preg,
  output logic [$clog2(NUM_PHYS)-1:0]       head_preg,
  output logic                              empty,
  output logic [$clog2(NUM_PHYS+1)-1:0]     count
);
  localparam int PW   = $clog2(NUM_PHYS);
  localparam int CW   = $clog2(NUM_PHYS + 1);
  localparam int INIT = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] slot_q [NUM_PHYS];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slot_q[i] <= (i < INIT) ? PW'(NUM_ARCH + i) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT % NUM_PHYS);
      cnt_q <= CW'(INIT);
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_preg;
        wr_q         <= PW'(rn_pkg::ring_next(int'(wr_q), NUM_PHYS));
      end
      if (pop)
        rd_q <= PW'(rn_pkg::ring_next(int'(rd_q), NUM_PHYS));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_preg = slot_q[rd_q];
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(NUM_PHYS));

endmodule

// File: rtl/rn_history.sv
module rn_history #(
  parameter int DEPTH = 8,
  parameter int EW    = 12   // entry width; bit EW-1 flags a destination
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [EW-1:0]                 push_ent,
  input  logic                          pop_old,
  input  logic                          pop_young,
  output logic [EW-1:0]                 old_ent,
  output logic [EW-1:0]                 young_ent,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+1)-1:0]    dst_cnt
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] ent_q [DEPTH];
  logic [IW-1:0] hd_q, tl_q, young_idx;
  logic [CW-1:0] cnt_q, dcnt_q;

  assign young_idx = IW'(rn_pkg::ring_prev(int'(tl_q), DEPTH));
  assign old_ent   = ent_q[hd_q];
  assign young_ent = ent_q[young_idx];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign dst_cnt   = dcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      cnt_q  <= '0;
      dcnt_q <= '0;
    end else begin
      if (push) begin
        ent_q[tl_q] <= push_ent;
        tl_q        <= IW'(rn_pkg::ring_next(int'(tl_q), DEPTH));
      end else if (pop_young) begin
        tl_q <= young_idx;
      end
      if (pop_old)
        hd_q <= IW'(rn_pkg::ring_next(int'(hd_q), DEPTH));
      cnt_q  <= cnt_q + CW'(push) - CW'(pop_old) - CW'(pop_young);
      dcnt_q <= dcnt_q + CW'(push && push_ent[EW-1])
                       - CW'(pop_old && old_ent[EW-1])
                       - CW'(pop_young && young_ent[EW-1]);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_old || pop_young) |-> !empty);
  p_one_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_young && (pop_old || push)));

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int DEPTH    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  output logic                          dec_ready,
  input  logic                          dec_has_dst,
  input  logic [$clog2(NUM_ARCH)-1:0]   dec_src_a,
  input  logic [$clog2(NUM_ARCH)-1:0]   dec_src_b,
  input  logic [$clog2(NUM_ARCH)-1:0]   dec_dst,
  output logic [$clog2(NUM_PHYS)-1:0]   ren_psrc_a,
  output logic                          ren_psrc_a_rdy,
  output logic [$clog2(NUM_PHYS)-1:0]   ren_psrc_b,
  output logic                          ren_psrc_b_rdy,
  output logic [$clog2(NUM_PHYS)-1:0]   ren_pdst,
  output logic [$clog2(NUM_PHYS)-1:0]   ren_pold,
  input  logic                          wb_valid,
  input  logic [$clog2(NUM_PHYS)-1:0]   wb_preg,
  input  logic                          cmt_valid,
  input  logic                          trap,
  output logic                          rec_done
);
  import rn_pkg::*;

  localparam int AW  = $clog2(NUM_ARCH);
  localparam int PW  = $clog2(NUM_PHYS);
  localparam int FCW = $clog2(NUM_PHYS + 1);
  localparam int HCW = $clog2(DEPTH + 1);
  localparam int EW  = 1 + AW + 2 * PW;

  typedef struct packed {
    logic          hd;     // must stay the top bit
    logic [AW-1:0] dst;
    logic [PW-1:0] pnew;
    logic [PW-1:0] pold;
  } rec_t;

  rn_mode_e      mode_q;
  logic [PW-1:0] map_q [NUM_ARCH];
  logic [NUM_PHYS-1:0] rdy_q;

  // Named internal events
  logic dec_fire, alloc, do_commit, undo_step, fl_push;
  logic [PW-1:0]  fl_head, fl_push_preg;
  logic           fl_empty, h_empty, h_full;
  logic [FCW-1:0] fl_count;
  logic [HCW-1:0] h_dst;
  rec_t           new_rec, old_rec, young_rec;
  logic [EW-1:0]  old_raw, young_raw;

  assign dec_ready = (mode_q == MODE_RUN) && !trap && !fl_empty && !h_full;
  assign dec_fire  = dec_valid && dec_ready;
  assign alloc     = dec_fire && dec_has_dst;
  assign do_commit = (mode_q == MODE_RUN) && !trap && cmt_valid && !h_empty;
  assign undo_step = (mode_q == MODE_UNDO) && !h_empty;
  assign rec_done  = (mode_q == MODE_UNDO) && h_empty;

  assign old_rec   = rec_t'(old_raw);
  assign young_rec = rec_t'(young_raw);

  assign ren_psrc_a     = map_q[dec_src_a];
  assign ren_psrc_b     = map_q[dec_src_b];
  assign ren_psrc_a_rdy = rdy_q[ren_psrc_a];
  assign ren_psrc_b_rdy = rdy_q[ren_psrc_b];
  assign ren_pdst       = fl_head;
  assign ren_pold       = map_q[dec_dst];

  assign new_rec = '{hd: dec_has_dst, dst: dec_dst,
                     pnew: dec_has_dst ? fl_head : '0, pold: map_q[dec_dst]};

  assign fl_push      = (do_commit && old_rec.hd) || (undo_step && young_rec.hd);
  assign fl_push_preg = undo_step ? young_rec.pnew : old_rec.pold;

  rn_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
    .clk(clk), .rst_n(rst_n), .pop(alloc), .push(fl_push),
    .push_preg(fl_push_preg), .head_preg(fl_head), .empty(fl_empty),
    .count(fl_count)
  );

  rn_history #(.DEPTH(DEPTH), .EW(EW)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(dec_fire), .push_ent(new_rec),
    .pop_old(do_commit), .pop_young(undo_step), .old_ent(old_raw),
    .young_ent(young_raw), .empty(h_empty), .full(h_full), .dst_cnt(h_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (undo_step && young_rec.hd) begin
      map_q[young_rec.dst] <= young_rec.pold;
    end else if (alloc) begin
      map_q[dec_dst] <= fl_head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '1;
    end else begin
      if (wb_valid) rdy_q[wb_preg] <= 1'b1;
      if (alloc)    rdy_q[fl_head] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               mode_q <= MODE_RUN;
    else if (mode_q == MODE_RUN && trap)      mode_q <= MODE_UNDO;
    else if (mode_q == MODE_UNDO && h_empty)  mode_q <= MODE_RUN;
  end

  p_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fl_count) + 32'(h_dst) == 32'(NUM_PHYS - NUM_ARCH));
  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_UNDO) |-> !dec_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);
  p_alloc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !rdy_q[$past(fl_head)]);
  p_map_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> map_q[$past(dec_dst)] == $past(fl_head));
  p_commit_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_commit && old_rec.hd) |-> (map_q[old_rec.dst] != old_rec.pold &&
                                   old_rec.pnew != old_rec.pold));
  p_trap_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_UNDO && !h_empty) |=> mode_q == MODE_UNDO);

endmodule

// File: tb/tb_reg_rename.sv
`timescale 1ns/1ps
module tb_reg_rename;
  localparam int NA = 8, NP = 16, DEP = 8;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_has_dst = 0, wb_valid = 0, cmt_valid = 0, trap = 0;
  logic [2:0] dec_src_a = 0, dec_src_b = 0, dec_dst = 0;
  logic [3:0] wb_preg = 0;
  logic dec_ready, ren_psrc_a_rdy, ren_psrc_b_rdy, rec_done;
  logic [3:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;

  always #4 clk = ~clk;

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_has_dst(dec_has_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_dst(dec_dst), .ren_psrc_a(ren_psrc_a), .ren_psrc_a_rdy(ren_psrc_a_rdy),
    .ren_psrc_b(ren_psrc_b), .ren_psrc_b_rdy(ren_psrc_b_rdy),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold), .wb_valid(wb_valid),
    .wb_preg(wb_preg), .cmt_valid(cmt_valid), .trap(trap), .rec_done(rec_done)
  );

  typedef struct { bit hd; int dst; int pnew; int pold; } ent_t;
  ent_t hist[$];
  int   free_q[$];
  int   map[NA];
  bit   rdy[NP];
  bit   m_undo;
  int   checks = 0, failures = 0;
  int   done_seen = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist.delete(); free_q.delete();
    for (int i = 0; i < NA; i++) map[i] = i;
    for (int i = 0; i < NP; i++) rdy[i] = 1;
    for (int i = NA; i < NP; i++) free_q.push_back(i);
    m_undo = 0;
  endtask

  // One clock: compare at the falling edge, advance the model, release inputs.
  task automatic tick();
    bit exp_ready, fire;
    ent_t e;
    @(negedge clk);
    exp_ready = !m_undo && !trap && free_q.size() > 0 && hist.size() < DEP;
    fire = dec_valid && exp_ready;
    chk("R6 dec_ready", int'(dec_ready), int'(exp_ready));
    chk("R8 rec_done", int'(rec_done), int'(m_undo && hist.size() == 0));
    if (rec_done) done_seen++;
    if (fire) begin
      chk("R2 psrc_a", int'(ren_psrc_a), map[dec_src_a]);
      chk("R2 psrc_b", int'(ren_psrc_b), map[dec_src_b]);
      chk("R4 psrc_a_rdy", int'(ren_psrc_a_rdy), int'(rdy[map[dec_src_a]]));
      chk("R4 psrc_b_rdy", int'(ren_psrc_b_rdy), int'(rdy[map[dec_src_b]]));
      if (dec_has_dst) begin
        chk("R3 pdst", int'(ren_pdst), free_q[0]);
        chk("R3 pold", int'(ren_pold), map[dec_dst]);
      end
    end
    if (wb_valid) rdy[wb_preg] = 1;
    if (m_undo) begin
      if (hist.size() > 0) begin
        e = hist.pop_back();
        if (e.hd) begin map[e.dst] = e.pold; free_q.push_back(e.pnew); end
      end else m_undo = 0;
    end else if (trap) begin
      m_undo = 1;
    end else begin
      if (cmt_valid && hist.size() > 0) begin
        e = hist.pop_front();
        if (e.hd) free_q.push_back(e.pold);
      end
      if (fire) begin
        e.hd = dec_has_dst; e.dst = dec_dst; e.pold = map[dec_dst]; e.pnew = 0;
        if (e.hd) begin
          e.pnew = free_q.pop_front();
          map[e.dst] = e.pnew;
          rdy[e.pnew] = 0;
        end
        hist.push_back(e);
      end
    end
    @(posedge clk); #1;
    dec_valid = 0; dec_has_dst = 0; wb_valid = 0; cmt_valid = 0; trap = 0;
  endtask

  task automatic dec(bit hd, int d, int a, int b);
    dec_valid = 1; dec_has_dst = hd; dec_dst = 3'(d);
    dec_src_a = 3'(a); dec_src_b = 3'(b);
    tick();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset mapping, readiness and free list head
    for (int i = 0; i < NA; i++) begin
      dec_src_a = 3'(i); #1;
      chk("R1 identity map", int'(ren_psrc_a), i);
      chk("R1 ready after reset", int'(ren_psrc_a_rdy), 1);
    end
    chk("R1 free head", int'(ren_pdst), NA);
    chk("R1 dec_ready", int'(dec_ready), 1);
    // R2/R3: chain of writers, source equal to own destination
    dec(1, 1, 3, 3);
    dec(1, 3, 1, 3);
    dec(0, 0, 3, 1);
    dec(1, 6, 7, 6);
    // R4: writeback sets presence
    wb_valid = 1; wb_preg = 4'(NA); tick();
    dec(1, 3, 1, 3);
    // R5: commit frees old mappings in order, commit on empty ignored
    repeat (6) begin cmt_valid = 1; tick(); end
    chk("R5 history drained", hist.size(), 0);
    cmt_valid = 1; tick();
    // R6/R9: fill every free register; record full and free list empty
    for (int i = 0; i < DEP; i++) dec(1, i, i, (i + 1) % NA);
    chk("R9 free regs all in flight", free_q.size(), 0);
    d0 = map[2];
    dec(1, 2, 2, 2);   // stalled, must not change anything
    dec_src_a = 3'd2; #1;
    chk("R6 stalled decode left map", int'(ren_psrc_a), d0);
    // R7/R10: trap with a full record, commit and second trap during walk
    trap = 1; tick();
    cmt_valid = 1; tick();
    trap = 1; tick();
    repeat (DEP) tick();
    chk("R8 single done pulse", done_seen, 1);
    for (int i = 0; i < NA; i++) begin
      dec_src_a = 3'(i); #1;
      chk("R7 restored map", int'(ren_psrc_a), map[i]);
    end
    // R8: trap with empty history
    trap = 1; tick();
    tick();
    chk("R8 done after empty trap", done_seen, 2);
    // Random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      dec_valid   = ($urandom_range(0, 9) < 7);
      dec_has_dst = ($urandom_range(0, 9) < 8);
      dec_dst     = 3'($urandom_range(0, NA - 1));
      dec_src_a   = 3'($urandom_range(0, NA - 1));
      dec_src_b   = 3'($urandom_range(0, NA - 1));
      cmt_valid   = ($urandom_range(0, 9) < 4);
      wb_valid    = ($urandom_range(0, 1) == 1);
      wb_preg     = 4'($urandom_range(0, NP - 1));
      trap        = ($urandom_range(0, 59) == 0);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule